// File: doc/BRIEF.md
# Keypad Ghost Filter and Key-Change Event Generator

This block sits behind a matrix keypad scanner. Each scan produces a snapshot of up to eight pressed-key slots, and each slot holds a 4-bit row index and a 3-bit column index. The block accepts one snapshot at a time and turns it into scan codes. It can reject the snapshot when three or more keys form a row/column ghost pattern. It can also move the codes into an upper layer while a designated function key is held.

When a snapshot is accepted, the block compares it with the key set it accepted last time. It then emits a burst of events on a valid/ready stream:
- a release event for each previously held key that has gone;
- a press event for every key in the new snapshot;
- a one-cycle sync pulse after the last event.

The new set then becomes the stored set. An empty snapshot stands for the all-released condition.

Top module: `keyscan_event_gen`

## Requirements
- R1: Slot i of the snapshot bus occupies bits [7i+6:7i], with the row in the upper 4 bits and the column in the lower 3. Its scan code is the 8-bit value {layer, row, col}, which equals row*8 + col plus 128 when the layer is active.
- R2: The ghost check applies only when `ghost_en` is high and at least 3 reported keys are present, counted after the function key has been removed. With `ghost_en` low, a ghost pattern is reported like any other snapshot.
- R3: A snapshot is discarded when some reported key has another key in its column and another key in its row. A discarded snapshot produces no event and no sync, and it leaves the stored set unchanged. `snap_ready` stays high afterwards.
- R4: When `fn_en` is high and the function key (parameter `FN_KEY`, default row 15, column 7) is in the snapshot, that key produces no event and every other code has bit 7 set. With `fn_en` low, the function key is an ordinary key.
- R5: Each stored key whose code is not in the new set produces a release event (`ev_press`=0). Releases come in stored-slot order.
- R6: Every key in the new set produces a press event (`ev_press`=1) in snapshot-slot order. All releases of a burst come before any of its presses.
- R7: After a burst, the new set replaces the stored set, and the next snapshot is compared against it.
- R8: An empty snapshot releases every stored key, emits no presses, and empties the stored set.
- R9: `ev_sync` is high for exactly one cycle after the last event of each accepted snapshot. This also happens when the snapshot produced no events.
- R10: `snap_ready` is high only while the block is idle. It is low from acceptance until the sync pulse, and no event is valid while it is high.
- R11: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_press` and `ev_code` hold steady.
- R12: After reset, `snap_ready` is high, no event or sync is pending, and the stored set is empty, so the first snapshot produces presses only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ghost_en | input | 1 | Enables the ghost-pattern rejection |
| fn_en | input | 1 | Enables the function-key layer |
| snap_valid | input | 1 | Snapshot offered |
| snap_ready | output | 1 | Block idle, snapshot can be taken |
| snap_mask | input | 8 | Slot occupied flags |
| snap_keys | input | 56 | Eight 7-bit {row, col} slots |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer takes the event |
| ev_press | output | 1 | 1 = press, 0 = release |
| ev_code | output | 8 | Scan code of the event |
| ev_sync | output | 1 | End of the events of one snapshot |

## Verification
The bench keeps the default parameters: eight slots, 4-bit rows, 3-bit columns and a function key at row 15, column 7. This gives the full 128-code plane and the 128 offset for the upper layer. Random snapshots draw rows and columns from a small pool, so ghost triangles, function-key removal that brings the count below three, and partial overlaps with the stored set all happen often. Random back-pressure on `ev_ready` exercises the hold rule and the release-before-press order.

// File: rtl/keyscan_event_gen.sv
module keyscan_event_gen #(
  parameter int ENTRIES = 8,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 3,
  parameter logic [ROW_W+COL_W-1:0] FN_KEY = '1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ghost_en,
  input  logic                             fn_en,
  input  logic                             snap_valid,
  output logic                             snap_ready,
  input  logic [ENTRIES-1:0]               snap_mask,
  input  logic [ENTRIES*(ROW_W+COL_W)-1:0] snap_keys,
  output logic                             ev_valid,
  input  logic                             ev_ready,
  output logic                             ev_press,
  output logic [ROW_W+COL_W:0]             ev_code,
  output logic                             ev_sync
);
  localparam int KW   = ROW_W + COL_W;
  localparam int CW   = KW + 1;
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNTW = $clog2(ENTRIES + 1);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_REL, S_PRS, S_SYNC} state_t;

  state_t             state;
  logic [IW-1:0]      idx;
  logic [ENTRIES-1:0] old_mask, new_mask;
  logic [CW-1:0]      old_code [ENTRIES];
  logic [CW-1:0]      new_code [ENTRIES];
  logic               layer_q;

  logic [KW-1:0]      raw  [ENTRIES];
  logic [CW-1:0]      ncode[ENTRIES];
  logic [ENTRIES-1:0] keep;
  logic               fn_seen, layer, ghost;
  logic [CNTW-1:0]    nkeys;
  logic               present, step;

  always_comb begin
    fn_seen = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      raw[i] = snap_keys[i*KW +: KW];
      if (snap_mask[i] && raw[i] == FN_KEY) fn_seen = 1'b1;
    end
    layer = fn_en && fn_seen;
    nkeys = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      keep[i]  = snap_mask[i] && !(layer && raw[i] == FN_KEY);
      ncode[i] = {layer, raw[i]};
      nkeys    = nkeys + CNTW'(keep[i]);
    end
  end

  always_comb begin
    logic sc, sr, hit;
    hit = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      sc = 1'b0;
      sr = 1'b0;
      for (int j = 0; j < ENTRIES; j++) begin
        if (j != i && keep[j]) begin
          if (raw[j][COL_W-1:0] == raw[i][COL_W-1:0]) sc = 1'b1;
          if (raw[j][KW-1:COL_W] == raw[i][KW-1:COL_W]) sr = 1'b1;
        end
      end
      if (keep[i] && sc && sr) hit = 1'b1;
    end
    ghost = ghost_en && (nkeys >= CNTW'(3)) && hit;
  end

  always_comb begin
    present = 1'b0;
    for (int j = 0; j < ENTRIES; j++)
      if (new_mask[j] && new_code[j] == old_code[idx]) present = 1'b1;
  end

  assign snap_ready = (state == S_IDLE);
  assign ev_press   = (state == S_PRS);
  assign ev_code    = ev_press ? new_code[idx] : old_code[idx];
  assign ev_sync    = (state == S_SYNC);
  assign ev_valid   = (state == S_REL && old_mask[idx] && !present) ||
                      (state == S_PRS && new_mask[idx]);
  assign step       = !ev_valid || ev_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      old_mask <= '0;
      new_mask <= '0;
      layer_q  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        old_code[i] <= '0;
        new_code[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (snap_valid && !ghost) begin
          new_mask <= keep;
          layer_q  <= layer;
          for (int i = 0; i < ENTRIES; i++) new_code[i] <= ncode[i];
          idx   <= '0;
          state <= S_REL;
        end
        S_REL: if (step) begin
          idx <= (idx == LAST) ? '0 : idx + 1'b1;
          if (idx == LAST) state <= S_PRS;
        end
        S_PRS: if (step) begin
          idx <= (idx == LAST) ? '0 : idx + 1'b1;
          if (idx == LAST) state <= S_SYNC;
        end
        default: begin
          old_mask <= new_mask;
          for (int i = 0; i < ENTRIES; i++) old_code[i] <= new_code[i];
          state <= S_IDLE;
        end
      endcase
    end
  end

  AST_READY_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n) ev_valid |-> !snap_ready); // R10
  AST_EVENT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press)); // R11
  AST_RELEASE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) ev_valid && ev_press |=> !(ev_valid && !ev_press)); // R6
  AST_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ev_sync |=> !ev_sync && snap_ready); // R9
  AST_LAYER_CODE: assert property (@(posedge clk) disable iff (!rst_n) ev_valid && ev_press |-> ev_code[KW] == layer_q); // R4
  AST_GHOST_DROP: assert property (@(posedge clk) disable iff (!rst_n) snap_valid && snap_ready && ghost |=> snap_ready && !ev_valid); // R3
endmodule

// File: tb/keyscan_event_gen_test.sv
module keyscan_event_gen_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ghost_en = 1'b0, fn_en = 1'b0, snap_valid = 1'b0, ev_ready = 1'b0;
  logic [7:0]  snap_mask = '0;
  logic [55:0] snap_keys = '0;
  logic        snap_ready, ev_valid, ev_press, ev_sync;
  logic [7:0]  ev_code;

  keyscan_event_gen uut (
    .clk(clk), .rst_n(rst_n), .ghost_en(ghost_en), .fn_en(fn_en),
    .snap_valid(snap_valid), .snap_ready(snap_ready), .snap_mask(snap_mask),
    .snap_keys(snap_keys), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_press(ev_press), .ev_code(ev_code), .ev_sync(ev_sync));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [6:0] s_key [8];
  logic [7:0] s_mask;
  logic [7:0] st_code [8];
  int         st_n = 0;
  logic [7:0] nl [8];
  int         nn;
  logic       exp_ghost;
  logic [7:0] e_code [16];
  logic       e_press [16];
  int         e_n;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model();
    logic fs, lay, hit, sc, sr, found;
    fs = 0;
    for (int i = 0; i < 8; i++) if (s_mask[i] && s_key[i] == 7'h7F) fs = 1;
    lay = fn_en && fs;
    nn = 0;
    for (int i = 0; i < 8; i++)
      if (s_mask[i] && !(lay && s_key[i] == 7'h7F)) begin nl[nn] = {lay, s_key[i]}; nn++; end
    hit = 0;
    for (int i = 0; i < nn; i++) begin
      sc = 0; sr = 0;
      for (int j = 0; j < nn; j++) if (j != i) begin
        if (nl[j][2:0] == nl[i][2:0]) sc = 1;
        if (nl[j][6:3] == nl[i][6:3]) sr = 1;
      end
      if (sc && sr) hit = 1;
    end
    exp_ghost = ghost_en && nn >= 3 && hit;
    e_n = 0;
    if (!exp_ghost) begin
      for (int i = 0; i < st_n; i++) begin
        found = 0;
        for (int j = 0; j < nn; j++) if (nl[j] == st_code[i]) found = 1;
        if (!found) begin e_code[e_n] = st_code[i]; e_press[e_n] = 0; e_n++; end
      end
      for (int j = 0; j < nn; j++) begin e_code[e_n] = nl[j]; e_press[e_n] = 1; e_n++; end
    end
  endtask

  task automatic run_snap(input logic randy);
    int got, cyc;
    logic done, pv, pp;
    logic [7:0] pc;
    model();
    @(negedge clk);
    chk(snap_ready === 1'b1, "R10 ready before snapshot", snap_ready, 1);
    for (int i = 0; i < 8; i++) snap_keys[i*7 +: 7] = s_key[i];
    snap_mask = s_mask;
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
    if (exp_ghost) begin
      done = 1;
      for (int c = 0; c < 12; c++) begin
        if (ev_valid || ev_sync || !snap_ready) done = 0;
        @(negedge clk);
      end
      chk(done, "R3 ghost snapshot discarded", done, 1);
      return;
    end
    chk(snap_ready === 1'b0, "R10 busy after accept", snap_ready, 0);
    got = 0; cyc = 0; done = 0; pv = 0; pp = 0; pc = 0;
    while (!done) begin
      ev_ready = randy ? ($urandom % 3 != 0) : 1'b1;
      if (pv) chk(ev_valid && ev_press == pp && ev_code == pc, "R11 hold under back-pressure", ev_code, pc);
      if (ev_valid && ev_ready) begin
        if (got < e_n) begin
          chk(ev_press == e_press[got], e_press[got] ? "R6 press order" : "R5 release order", ev_press, e_press[got]);
          chk(ev_code == e_code[got], "R1/R4 event code", ev_code, e_code[got]);
        end else chk(0, "R5/R6 extra event", got, e_n);
        got++;
      end
      pv = ev_valid && !ev_ready; pp = ev_press; pc = ev_code;
      if (ev_sync) done = 1;
      @(negedge clk);
      cyc++;
      if (cyc > 300) begin chk(0, "R9 sync never seen", cyc, 0); done = 1; end
    end
    ev_ready = 1'b0;
    chk(got == e_n, "R9 event count per snapshot", got, e_n);
    chk(!ev_sync && snap_ready, "R9 single sync then idle", ev_sync, 0);
    st_n = nn;
    for (int i = 0; i < nn; i++) st_code[i] = nl[i];
  endtask

  task automatic clear_snap();
    s_mask = '0;
    for (int i = 0; i < 8; i++) s_key[i] = '0;
  endtask

  task automatic put(input int slot, input int row, input int col);
    s_key[slot] = {row[3:0], col[2:0]};
    s_mask[slot] = 1'b1;
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(snap_ready === 1'b1 && ev_valid === 1'b0 && ev_sync === 1'b0, "R12 reset state", {snap_ready, ev_valid, ev_sync}, 3'b100);

    clear_snap(); put(0, 3, 5);                          run_snap(0); // R12 R1 code 0x1D
    clear_snap(); put(1, 2, 0); put(0, 3, 5);            run_snap(0); // R6
    clear_snap(); put(0, 2, 0); put(1, 4, 4);            run_snap(1); // R5 R7
    ghost_en = 1;
    clear_snap(); put(0, 1, 1); put(1, 1, 2); put(2, 2, 1); run_snap(0); // R3
    clear_snap(); put(0, 1, 1);                          run_snap(0); // R3 stored set kept, R7
    ghost_en = 0;
    clear_snap(); put(0, 1, 1); put(1, 1, 2); put(2, 2, 1); run_snap(0); // R2
    ghost_en = 1;
    clear_snap(); put(0, 1, 1); put(1, 1, 2);            run_snap(0); // R2 two keys never ghost
    fn_en = 1;
    clear_snap(); put(0, 15, 7); put(1, 2, 3);           run_snap(1); // R4 0x93
    clear_snap(); put(0, 1, 1); put(1, 15, 7); put(2, 1, 2); put(3, 2, 1); run_snap(0); // R3 after fn removal
    fn_en = 0;
    clear_snap(); put(0, 15, 7); put(1, 2, 3);           run_snap(0); // R4 fn plain
    clear_snap();                                         run_snap(1); // R8
    clear_snap();                                         run_snap(0); // R8 R9 no events

    for (int n = 0; n < 400; n++) begin
      ghost_en = $urandom % 2;
      fn_en = $urandom % 2;
      clear_snap();
      for (int i = 0; i < 8; i++) begin
        s_mask[i] = ($urandom % 3 == 0);
        s_key[i] = ($urandom % 6 == 0) ? 7'h7F : {4'($urandom % 4), 3'($urandom % 4)};
      end
      if ($urandom % 10 == 0) s_mask = '0;
      run_snap(1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule